// File: doc/BRIEF.md
# I2C Register-Access Slave Controller

This block lets an I2C master read and write a 256-byte address space that sits behind it. The block samples SCL and SDA with the system clock and cleans them up before use. It finds start, repeated start and stop conditions. It answers to a 7-bit device address whose lowest bit comes from a strap pin.

Inside the block, an 8-bit pointer selects the location that is accessed. In a write, the byte that follows the device address loads the pointer. Every later byte of that write becomes a one-cycle store strobe, with the pointer on the address output and the byte on the write-data output. After each store the pointer steps forward but stays inside its 8-byte row. In a read, the byte is taken from the read-data input at the current pointer. The pointer then steps forward through the whole space and rolls from FFh to 00h.

A busy input marks a nonvolatile commit in progress. While it is high the block does not acknowledge its own address, so a master can poll until the commit is done. The block never stretches SCL. It drives SDA only by pulling it low, through a single output enable.

Top module: `i2c_regslave`

## Requirements
- R1: The device address is 7'b101000p, where p is the level on `dev_pin_i`. The address byte is sent MSB first and its LSB is R/W (0 write, 1 read). A matching address is acknowledged by pulling SDA low in the ninth clock; a non-matching address leaves SDA released.
- R2: In a write, the first byte after the address byte loads the pointer and produces no store. Each later byte is acknowledged and produces exactly one `wr_stb_o` pulse of one clock, with `addr_o` equal to the pointer and `wdata_o` equal to the byte.
- R3: After each stored byte, only the low 3 pointer bits increment and wrap. Three bytes written from 06h land at 06h, 07h, then 00h.
- R4: A write that carries only the pointer byte, followed by a repeated start and a read address byte, returns the byte at that pointer first.
- R5: During a read the pointer increments across row boundaries and rolls from FFh to 00h. A read from FEh returns the bytes at FEh, FFh, 00h, 01h.
- R6: A read with no preceding pointer byte starts at the current pointer, which is one past the last byte read.
- R7: A master NACK (SDA high in the ninth clock of a read byte) ends the read. SDA stays released until the next start.
- R8: While `busy_i` is high when the address byte completes, the address is not acknowledged. The data bytes that follow produce no store.
- R9: A start in any state restarts address reception at bit 0. Each stop returns the block to idle and pulses `stop_o` high for exactly one clock.
- R10: The block changes its SDA drive only while the filtered SCL is low. Read data bits are valid during the SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_pin_i | input | 1 | Strap that sets the address LSB |
| busy_i | input | 1 | Nonvolatile commit in progress |
| addr_o | output | 8 | Pointer into the register space |
| wdata_o | output | 8 | Byte to store |
| wr_stb_o | output | 1 | One-clock store strobe |
| rdata_i | input | 8 | Byte at `addr_o`, combinational from the register space |
| stop_o | output | 1 | One-clock pulse on each stop condition |

## Verification
The bench writes three bytes from 06h. A design that runs on linearly would corrupt 08h instead of wrapping to 00h. It reads four bytes from FEh, where a design that wraps inside the row on reads would return F8h data after FFh. It then does a bare read, which catches a pointer that is not advanced past the last byte read or that is reset by the stop. It polls with busy high, which exposes a design that acknowledges anyway or still stores the bytes that follow. It aborts an address byte halfway with a repeated start, which shows whether a stale bit count shifts the next address out of alignment.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [5:0] DEV_HI   = 6'b101000,
  parameter int         ROW_BITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       dev_pin_i,
  input  logic       busy_i,
  output logic [7:0] addr_o,
  output logic [7:0] wdata_o,
  output logic       wr_stb_o,
  input  logic [7:0] rdata_i,
  output logic       stop_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_DACK = 3'd2,
                         S_WR = 3'd3, S_WACK = 3'd4, S_RD = 3'd5, S_RACK = 3'd6;
  localparam logic [ROW_BITS-1:0] ROW_ONE = 1;

  logic [1:0] scl_sy, sda_sy;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_h  <= 3'b111; sda_h <= 3'b111;
      scl_f  <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[1:0], scl_sy[1]};
      sda_h  <= {sda_h[1:0], sda_sy[1]};
      scl_f  <= (scl_h[0] & scl_h[1]) | (scl_h[0] & scl_h[2]) | (scl_h[1] & scl_h[2]);
      sda_f  <= (sda_h[0] & sda_h[1]) | (sda_h[0] & sda_h[2]) | (sda_h[1] & sda_h[2]);
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end

  wire rise  = scl_f & ~scl_p;
  wire fall  = ~scl_f & scl_p;
  wire start = scl_f & scl_p & sda_p & ~sda_f;
  wire stop  = scl_f & scl_p & ~sda_p & sda_f;

  logic [2:0] st;
  logic [3:0] bitcnt;
  logic [7:0] sr, ptr;
  logic       rw, need_ptr, wrote, rnack;

  assign addr_o  = ptr;
  assign wdata_o = sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sr <= '0; ptr <= '0;
      rw <= 1'b0; need_ptr <= 1'b0; wrote <= 1'b0; rnack <= 1'b0;
      sda_oe_o <= 1'b0; wr_stb_o <= 1'b0; stop_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      stop_o   <= 1'b0;
      if (stop) begin
        st <= S_IDLE; bitcnt <= '0; sda_oe_o <= 1'b0; stop_o <= 1'b1;
      end else if (start) begin
        st <= S_DEV; bitcnt <= '0; sda_oe_o <= 1'b0;
      end else if (rise) begin
        if (st == S_DEV || st == S_WR) begin
          sr     <= {sr[6:0], sda_f};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RACK)
          rnack <= sda_f;
      end else if (fall) begin
        case (st)
          S_DEV: if (bitcnt == 4'd8) begin
            if (sr[7:1] == {DEV_HI, dev_pin_i} && !busy_i) begin
              sda_oe_o <= 1'b1; rw <= sr[0]; st <= S_DACK;
            end else
              st <= S_IDLE;
          end
          S_DACK: if (rw) begin
            sda_oe_o <= ~rdata_i[7]; sr <= {rdata_i[6:0], 1'b0};
            bitcnt <= 4'd1; st <= S_RD;
          end else begin
            sda_oe_o <= 1'b0; bitcnt <= '0; need_ptr <= 1'b1; st <= S_WR;
          end
          S_WR: if (bitcnt == 4'd8) begin
            sda_oe_o <= 1'b1; st <= S_WACK;
            if (need_ptr) begin
              ptr <= sr; need_ptr <= 1'b0; wrote <= 1'b0;
            end else begin
              wr_stb_o <= 1'b1; wrote <= 1'b1;
            end
          end
          S_WACK: begin
            sda_oe_o <= 1'b0; bitcnt <= '0; st <= S_WR;
            if (wrote) ptr <= {ptr[7:ROW_BITS], ptr[ROW_BITS-1:0] + ROW_ONE};
          end
          S_RD: if (bitcnt == 4'd8) begin
            sda_oe_o <= 1'b0; ptr <= ptr + 8'd1; st <= S_RACK;
          end else begin
            sda_oe_o <= ~sr[7]; sr <= {sr[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1;
          end
          S_RACK: if (rnack)
            st <= S_IDLE;
          else begin
            sda_oe_o <= ~rdata_i[7]; sr <= {rdata_i[6:0], 1'b0};
            bitcnt <= 4'd1; st <= S_RD;
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic [2:0] st,
  input logic       sda_oe_o,
  input logic       wr_stb_o,
  input logic       stop_o,
  input logic       busy_i
);
  a_r9_stop_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
  a_r2_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_f);
  a_r8_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && $past(st) == 3'd1) |-> !$past(busy_i));
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe_o);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .st(st),
  .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .stop_o(stop_o), .busy_i(busy_i)
);

// File: tb/test_i2c_regslave.sv
`timescale 1ns/1ps
module test_i2c_regslave;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_lo = 1'b0;
  logic dev_pin = 1'b0, busy = 1'b0;
  logic sda_oe, wr_stb, stop_p;
  logic [7:0] addr, wdata;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  wire sda_bus = ~(sda_oe | m_sda_lo);
  int checks = 0, errors = 0, stb_cnt = 0, stop_cnt = 0, stops_sent = 0;

  i2c_regslave i_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .dev_pin_i(dev_pin), .busy_i(busy), .addr_o(addr), .wdata_o(wdata),
    .wr_stb_o(wr_stb), .rdata_i(mem[addr]), .stop_o(stop_p)
  );

  always @(posedge clk) begin
    if (wr_stb) begin mem[addr] <= wdata; stb_cnt <= stb_cnt + 1; end
    if (stop_p) stop_cnt <= stop_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic xbit(input logic b, output logic r);
    wq(Q); m_sda_lo = ~b; wq(Q); m_scl = 1'b1; wq(Q); r = sda_bus; wq(Q); m_scl = 1'b0;
  endtask

  task automatic m_start;
    wq(Q); m_sda_lo = 1'b0; m_scl = 1'b1; wq(2*Q); m_sda_lo = 1'b1; wq(2*Q); m_scl = 1'b0;
  endtask

  task automatic m_stop;
    wq(Q); m_sda_lo = 1'b1; wq(Q); m_scl = 1'b1; wq(2*Q); m_sda_lo = 1'b0; wq(2*Q);
    stops_sent++;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(d[i], r);
    xbit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin xbit(1'b1, r); d = {d[6:0], r}; end
    xbit(~ack, r);
  endtask

  task automatic t_reset;
    check("R9 reset sda", 32'(sda_oe), 0);
    check("R2 reset strobe", 32'(wr_stb), 0);
    check("R9 reset stop", 32'(stop_p), 0);
  endtask

  task automatic t_addr_match;
    logic a;
    m_start; wbyte(8'hA2, a); check("R1 wrong address nack", 32'(a), 0); m_stop;
    m_start; wbyte(8'hA0, a); check("R1 own address ack", 32'(a), 1); m_stop;
  endtask

  task automatic t_single_write;
    logic a; int s0;
    s0 = stb_cnt;
    m_start; wbyte(8'hA0, a); wbyte(8'h10, a); wbyte(8'hA5, a);
    check("R2 data ack", 32'(a), 1); m_stop;
    expm[8'h10] = 8'hA5;
    check("R2 stored byte", 32'(mem[8'h10]), 32'(expm[8'h10]));
    check("R2 one strobe", 32'(stb_cnt - s0), 1);
  endtask

  task automatic t_row_wrap;
    logic a;
    m_start; wbyte(8'hA0, a); wbyte(8'h06, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); m_stop;
    expm[8'h06] = 8'h11; expm[8'h07] = 8'h22; expm[8'h00] = 8'h33;
    check("R3 06h", 32'(mem[8'h06]), 32'h11);
    check("R3 07h", 32'(mem[8'h07]), 32'h22);
    check("R3 wrap to 00h", 32'(mem[8'h00]), 32'h33);
    check("R3 08h untouched", 32'(mem[8'h08]), 32'(expm[8'h08]));
  endtask

  task automatic t_random_read;
    logic a; logic [7:0] d;
    m_start; wbyte(8'hA0, a); wbyte(8'h07, a);
    m_start; wbyte(8'hA1, a); rbyte(1'b0, d);
    check("R4 random read", 32'(d), 32'(expm[8'h07]));
    wq(Q); check("R7 released after nack", 32'(sda_oe), 0);
    m_stop;
  endtask

  task automatic t_seq_read;
    logic a; logic [7:0] d;
    m_start; wbyte(8'hA0, a); wbyte(8'hFE, a);
    m_start; wbyte(8'hA1, a);
    for (int k = 0; k < 4; k++) begin
      rbyte(k != 3, d);
      check("R5 sequential rollover", 32'(d), 32'(expm[8'(8'hFE + k)]));
    end
    m_stop;
  endtask

  task automatic t_current_read;
    logic a; logic [7:0] d;
    m_start; wbyte(8'hA1, a); rbyte(1'b0, d); m_stop;
    check("R6 current address read", 32'(d), 32'(expm[8'h02]));
  endtask

  task automatic t_busy;
    logic a; int s0;
    s0 = stb_cnt; busy = 1'b1;
    m_start; wbyte(8'hA0, a); check("R8 busy nack", 32'(a), 0);
    wbyte(8'h20, a); wbyte(8'h5A, a); m_stop;
    busy = 1'b0;
    check("R8 no store while busy", 32'(mem[8'h20]), 32'(expm[8'h20]));
    check("R8 no strobe while busy", 32'(stb_cnt - s0), 0);
    m_start; wbyte(8'hA0, a); check("R8 ack after busy", 32'(a), 1); m_stop;
  endtask

  task automatic t_abort;
    logic a, r; logic [7:0] d;
    m_start; xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r);
    m_start; wbyte(8'hA0, a); wbyte(8'h10, a);
    m_start; wbyte(8'hA1, a); check("R9 restart realigns", 32'(a), 1);
    rbyte(1'b0, d); m_stop;
    check("R9 read after abort", 32'(d), 32'(expm[8'h10]));
  endtask

  task automatic t_pin_one;
    logic a;
    dev_pin = 1'b1; wq(4);
    m_start; wbyte(8'hA0, a); check("R1 pin one rejects p=0", 32'(a), 0); m_stop;
    m_start; wbyte(8'hA2, a); check("R1 pin one accepts p=1", 32'(a), 1); m_stop;
    dev_pin = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      expm[i] = 8'(i * 7 + 3);
    end
    wq(5); t_reset; rst_n = 1'b1; wq(10);
    t_addr_match;
    t_single_write;
    t_row_wrap;
    t_random_read;
    t_seq_read;
    t_current_read;
    t_busy;
    t_abort;
    t_pin_one;
    wq(10);
    check("R9 one stop pulse per stop", 32'(stop_cnt), 32'(stops_sent));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule